// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide parallel flash whose program and erase operations are started by two bus write cycles. It runs the quick-pulse algorithms without software help. A program request names a start address and a byte count. The bytes themselves arrive on a valid/ready stream, one byte for each address in ascending order. An erase request names the same kind of range. The block first programs every byte of that range to 00h. It then applies erase pulses and verifies each address until it reads back FFh.

Each pulse is followed by a verify command, a settling wait and a read-back compare. A byte that does not compare receives another pulse at the same address. A pulse counter, cleared whenever the address advances, bounds the retries. When the sequence ends, the block writes the read-array command, drops the programming-supply enable and pulses `done` with a pass flag. On a failure it also reports the address that failed. All waits are parameters counted in clock cycles.

Stream rule: `wr_ready` is high only while the sequencer waits for the next program byte. A byte transfers on a cycle where `wr_valid` and `wr_ready` are both high. The source must hold `wr_data` steady while `wr_valid` is high and no transfer has happened. The sequencer may hold `wr_ready` low for as long as a byte's pulse and verify loop lasts.

Top module: `flash_pe_seq`

## Requirements
- R1: Out of reset, and whenever idle, `busy`, `done`, `vpp_en`, `fl_we`, `fl_re` and `wr_ready` are all low.
- R2: Every bus access is a single-cycle strobe on `fl_we` or `fl_re`, and the two are never high together. The command bytes are: 40h program setup, C0h program verify, 20h erase setup, 20h erase confirm, A0h erase verify and 00h read array. Setup, data and verify writes carry the current address.
- R3: A program operation visits addresses start to start+count_m1 in ascending order. For each address it accepts exactly one stream byte, then writes 40h, then writes the byte, then writes C0h, then reads the byte back.
- R4: When the read-back differs from the intended byte, another pulse (40h, then the same byte) is issued at the same address and no new stream byte is taken.
- R5: A byte that still differs after PROG_MAX pulses ends the operation with `pass` low and `fail_addr` set to that address. No later address is touched.
- R6: An erase operation first programs every byte of its range to 00h using the program loop of R3 and R4, and takes no stream bytes. Only after that does it write any erase command.
- R7: In the erase phase, the first address receives one erase pulse (20h, 20h) before its first verify. A verify read of FFh advances directly to the next address's verify. Any other value gives another erase pulse at the same address.
- R8: The erase pulse count is bounded by ERASE_MAX per address and cleared when the address advances. Exceeding the bound ends the operation with `pass` low and `fail_addr` set to that address.
- R9: There are exactly T_PROG_CYC idle cycles between a program data write and its verify command, and exactly T_ERASE_CYC idle cycles between an erase confirm and the following verify command. There are exactly T_VFY_CYC idle cycles between a verify command and its read.
- R10: `vpp_en` is high from the cycle after a start through the final 00h write. After that write, `vpp_en` falls and `done` is high for exactly one cycle. `pass` and `fail_addr` are valid in that cycle.
- R11: Start requests arriving while busy are ignored. If both starts arrive together while idle, the program operation runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_start | input | 1 | Start a program operation (sampled while idle) |
| erase_start | input | 1 | Start an erase operation (sampled while idle) |
| op_addr | input | ADDR_W | First address of the range |
| op_count_m1 | input | ADDR_W | Number of bytes in the range minus one |
| wr_valid | input | 1 | Program byte stream valid |
| wr_ready | output | 1 | Sequencer ready for a program byte |
| wr_data | input | 8 | Program byte |
| fl_addr | output | ADDR_W | Flash address |
| fl_wdata | output | 8 | Flash write data or command byte |
| fl_we | output | 1 | Flash write strobe (one cycle) |
| fl_re | output | 1 | Flash read strobe; `fl_rdata` sampled at the end of that cycle |
| fl_rdata | input | 8 | Flash read data |
| vpp_en | output | 1 | Programming-supply enable |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| pass | output | 1 | Result of the last operation |
| fail_addr | output | ADDR_W | Address that exhausted its pulse budget |

## Verification
A behavioural flash model in the bench gives each byte its own number of program pulses before it takes a value. It also gives each byte a threshold of accumulated erase pulses before it reads FFh. The program loop is exercised four ways: with single-pulse bytes, which checks the basic handshake and ordering; with multi-pulse bytes, which exposes a wrong retry count; with a byte beyond the budget, which pins down the fail address and stops further stream consumption; and with FFh data, which must verify after a single pulse.

Erase runs use threshold patterns where the total pulse count exceeds ERASE_MAX while no single address does. Such a pattern distinguishes a counter that is cleared on each address advance from one that is never cleared. A separate pattern overruns the budget at the second address. Random program and erase ranges with random stream stalls are added on top, and the model measures every command spacing against the configured waits.

// File: rtl/flseq_pkg.sv
package flseq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_FETCH,
    S_P_SETUP,
    S_P_DATA,
    S_P_WAIT,
    S_P_VCMD,
    S_P_VWAIT,
    S_P_READ,
    S_E_SETUP,
    S_E_CMD,
    S_E_WAIT,
    S_E_VCMD,
    S_E_VWAIT,
    S_E_READ,
    S_RDCMD,
    S_DONE
  } seq_state_t;

  localparam logic [7:0] CMD_READ_ARRAY  = 8'h00;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO    = 8'h20;
  localparam logic [7:0] CMD_ERASE_VFY   = 8'hA0;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_PROG_VFY    = 8'hC0;
  localparam logic [7:0] BYTE_ERASED     = 8'hFF;
  localparam logic [7:0] BYTE_ZERO       = 8'h00;

endpackage

// File: rtl/flseq_wait_timer.sv
module flseq_wait_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/flseq_pulse_ctr.sv
module flseq_pulse_ctr #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          bump,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (bump)  count <= count + 1'b1;
  end
endmodule

// File: rtl/flseq_addr_walk.sv
module flseq_addr_walk #(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] span_m1,
  input  logic          rewind,
  input  logic          step,
  output logic [AW-1:0] cur,
  output logic          last
);
  logic [AW-1:0] base_q, span_q, left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      span_q <= '0;
      cur    <= '0;
      left_q <= '0;
    end else if (load) begin
      base_q <= base;
      span_q <= span_m1;
      cur    <= base;
      left_q <= span_m1;
    end else if (rewind) begin
      cur    <= base_q;
      left_q <= span_q;
    end else if (step) begin
      cur    <= cur + 1'b1;
      left_q <= left_q - 1'b1;
    end
  end

  assign last = (left_q == '0);
endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
  import flseq_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int T_PROG_CYC  = 500,
  parameter int T_ERASE_CYC = 500000,
  parameter int T_VFY_CYC   = 300,
  parameter int PROG_MAX    = 25,
  parameter int ERASE_MAX   = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_start,
  input  logic              erase_start,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [ADDR_W-1:0] op_count_m1,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  output logic              fl_we,
  output logic              fl_re,
  input  logic [7:0]        fl_rdata,
  output logic              vpp_en,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] fail_addr
);
  localparam int TMAX0 = (T_ERASE_CYC > T_PROG_CYC) ? T_ERASE_CYC : T_PROG_CYC;
  localparam int TMAX  = (TMAX0 > T_VFY_CYC) ? TMAX0 : T_VFY_CYC;
  localparam int TCW   = $clog2(TMAX + 1);
  localparam int PMAX  = (ERASE_MAX > PROG_MAX) ? ERASE_MAX : PROG_MAX;
  localparam int PCW   = $clog2(PMAX + 1);

  localparam logic [TCW-1:0] LD_PROG  = TCW'(T_PROG_CYC - 1);
  localparam logic [TCW-1:0] LD_ERASE = TCW'(T_ERASE_CYC - 1);
  localparam logic [TCW-1:0] LD_VFY   = TCW'(T_VFY_CYC - 1);
  localparam logic [PCW-1:0] PROG_LIM  = PCW'(PROG_MAX);
  localparam logic [PCW-1:0] ERASE_LIM = PCW'(ERASE_MAX);

  seq_state_t st, nxt;
  logic        t_load, t_exp;
  logic [TCW-1:0] t_val;
  logic        p_clr, p_bump;
  logic [PCW-1:0] pulse_count;
  logic        a_load, a_rew, a_step, a_last;
  logic [ADDR_W-1:0] a_cur;
  logic        pre_q, vpp_q, pass_q, give_up;
  logic [7:0]  data_q;
  logic [ADDR_W-1:0] fail_q;
  logic        prog_ok, erase_ok;

  flseq_wait_timer #(.CW(TCW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  flseq_pulse_ctr #(.CW(PCW)) u_pulses (
    .clk(clk), .rst_n(rst_n), .clear(p_clr), .bump(p_bump), .count(pulse_count)
  );

  flseq_addr_walk #(.AW(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(a_load), .base(op_addr), .span_m1(op_count_m1),
    .rewind(a_rew), .step(a_step), .cur(a_cur), .last(a_last)
  );

  assign prog_ok  = (fl_rdata == data_q);
  assign erase_ok = (fl_rdata == BYTE_ERASED);

  always_comb begin
    nxt     = st;
    t_load  = 1'b0;
    t_val   = '0;
    p_clr   = 1'b0;
    p_bump  = 1'b0;
    a_load  = 1'b0;
    a_rew   = 1'b0;
    a_step  = 1'b0;
    give_up = 1'b0;
    case (st)
      S_IDLE: begin
        if (prog_start) begin
          nxt = S_FETCH; a_load = 1'b1; p_clr = 1'b1;
        end else if (erase_start) begin
          nxt = S_P_SETUP; a_load = 1'b1; p_clr = 1'b1;
        end
      end
      S_FETCH:   if (wr_valid) nxt = S_P_SETUP;
      S_P_SETUP: nxt = S_P_DATA;
      S_P_DATA: begin
        nxt = S_P_WAIT; t_load = 1'b1; t_val = LD_PROG; p_bump = 1'b1;
      end
      S_P_WAIT:  if (t_exp) nxt = S_P_VCMD;
      S_P_VCMD: begin
        nxt = S_P_VWAIT; t_load = 1'b1; t_val = LD_VFY;
      end
      S_P_VWAIT: if (t_exp) nxt = S_P_READ;
      S_P_READ: begin
        if (prog_ok) begin
          p_clr = 1'b1;
          if (a_last) begin
            if (pre_q) begin nxt = S_E_SETUP; a_rew = 1'b1; end
            else nxt = S_RDCMD;
          end else begin
            a_step = 1'b1;
            nxt    = pre_q ? S_P_SETUP : S_FETCH;
          end
        end else if (pulse_count >= PROG_LIM) begin
          give_up = 1'b1; nxt = S_RDCMD;
        end else begin
          nxt = S_P_SETUP;
        end
      end
      S_E_SETUP: nxt = S_E_CMD;
      S_E_CMD: begin
        nxt = S_E_WAIT; t_load = 1'b1; t_val = LD_ERASE; p_bump = 1'b1;
      end
      S_E_WAIT:  if (t_exp) nxt = S_E_VCMD;
      S_E_VCMD: begin
        nxt = S_E_VWAIT; t_load = 1'b1; t_val = LD_VFY;
      end
      S_E_VWAIT: if (t_exp) nxt = S_E_READ;
      S_E_READ: begin
        if (erase_ok) begin
          p_clr = 1'b1;
          if (a_last) nxt = S_RDCMD;
          else begin a_step = 1'b1; nxt = S_E_VCMD; end
        end else if (pulse_count >= ERASE_LIM) begin
          give_up = 1'b1; nxt = S_RDCMD;
        end else begin
          nxt = S_E_SETUP;
        end
      end
      S_RDCMD: nxt = S_DONE;
      S_DONE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pre_q  <= 1'b0;
      vpp_q  <= 1'b0;
      pass_q <= 1'b0;
      data_q <= '0;
      fail_q <= '0;
    end else begin
      st <= nxt;
      if (st == S_IDLE && (prog_start || erase_start)) begin
        vpp_q  <= 1'b1;
        pass_q <= 1'b1;
        fail_q <= '0;
        pre_q  <= !prog_start;
        data_q <= BYTE_ZERO;
      end
      if (st == S_FETCH && wr_valid) data_q <= wr_data;
      if (st == S_P_READ && nxt == S_E_SETUP) pre_q <= 1'b0;
      if (give_up) begin
        pass_q <= 1'b0;
        fail_q <= a_cur;
      end
      if (st == S_RDCMD) vpp_q <= 1'b0;
    end
  end

  always_comb begin
    fl_we    = 1'b1;
    fl_wdata = CMD_READ_ARRAY;
    case (st)
      S_P_SETUP: fl_wdata = CMD_PROG_SETUP;
      S_P_DATA:  fl_wdata = data_q;
      S_P_VCMD:  fl_wdata = CMD_PROG_VFY;
      S_E_SETUP: fl_wdata = CMD_ERASE_SETUP;
      S_E_CMD:   fl_wdata = CMD_ERASE_GO;
      S_E_VCMD:  fl_wdata = CMD_ERASE_VFY;
      S_RDCMD:   fl_wdata = CMD_READ_ARRAY;
      default:   fl_we    = 1'b0;
    endcase
  end

  assign fl_addr   = a_cur;
  assign fl_re     = (st == S_P_READ) || (st == S_E_READ);
  assign wr_ready  = (st == S_FETCH);
  assign vpp_en    = vpp_q;
  assign busy      = (st != S_IDLE) && (st != S_DONE);
  assign done      = (st == S_DONE);
  assign pass      = pass_q;
  assign fail_addr = fail_q;
endmodule

// File: rtl/flseq_checker.sv
module flseq_checker #(
  parameter int PCW       = 10,
  parameter int ERASE_MAX = 1000
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           vpp_en,
  input logic           fl_we,
  input logic           fl_re,
  input logic           wr_ready,
  input logic [PCW-1:0] pcnt
);
  // R2
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));

  // R2
  read_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_re |=> !fl_re);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!fl_re && !wr_ready && !(fl_we && !vpp_en)));

  // R10
  vpp_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we |-> vpp_en);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_vpp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!vpp_en && !busy));

  // R3
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (busy && vpp_en));

  // R8
  pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= PCW'(ERASE_MAX));
endmodule

bind flash_pe_seq flseq_checker #(.PCW(PCW), .ERASE_MAX(ERASE_MAX)) u_flseq_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .vpp_en(vpp_en),
  .fl_we(fl_we), .fl_re(fl_re), .wr_ready(wr_ready), .pcnt(pulse_count)
);

// File: tb/flash_pe_seq_bench.sv
module flash_pe_seq_bench;
  localparam int AW = 4;
  localparam int TP = 4;
  localparam int TE = 12;
  localparam int TV = 2;
  localparam int PM = 5;
  localparam int EM = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_start = 1'b0, erase_start = 1'b0;
  logic [AW-1:0] op_addr = '0, op_count_m1 = '0;
  logic wr_valid = 1'b0, wr_ready;
  logic [7:0] wr_data = '0;
  logic [AW-1:0] fl_addr, fail_addr;
  logic [7:0] fl_wdata, fl_rdata;
  logic fl_we, fl_re, vpp_en, busy, done, pass;

  always #10 clk = ~clk;

  flash_pe_seq #(.ADDR_W(AW), .T_PROG_CYC(TP), .T_ERASE_CYC(TE), .T_VFY_CYC(TV),
                 .PROG_MAX(PM), .ERASE_MAX(EM)) u_flash_pe_seq (
    .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .erase_start(erase_start),
    .op_addr(op_addr), .op_count_m1(op_count_m1), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata), .vpp_en(vpp_en),
    .busy(busy), .done(done), .pass(pass), .fail_addr(fail_addr)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural flash model ----------------
  logic [7:0] mem [16];
  int pneed [16], pcount [16], eneed [16];
  bit got00 [16];
  int cyc = 0, eglob, epulses, ptotal, cmd_st, last_was_econf;
  int t_data, t_econf, t_vcmd;
  int seq_err, time_err, vpp_err, pre_err, last_w;
  int rng_lo, rng_n;

  assign fl_rdata = mem[fl_addr];

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (fl_re && (cyc - t_vcmd != TV + 1)) time_err++;
      if (fl_we) begin
        if (!vpp_en) vpp_err++;
        last_w = fl_wdata;
        if (cmd_st == 1) begin
          pcount[fl_addr]++; ptotal++;
          if (pcount[fl_addr] >= pneed[fl_addr]) mem[fl_addr] = fl_wdata;
          if (fl_wdata == 8'h00) got00[fl_addr] = 1'b1;
          t_data = cyc; cmd_st = 0; last_was_econf = 0;
        end else if (cmd_st == 2) begin
          if (fl_wdata != 8'h20) seq_err++;
          eglob++; epulses++;
          for (int k = 0; k < 16; k++) if (eneed[k] <= eglob) mem[k] = 8'hFF;
          t_econf = cyc; cmd_st = 0; last_was_econf = 1;
        end else begin
          case (fl_wdata)
            8'h40: cmd_st = 1;
            8'h20: begin
              cmd_st = 2;
              for (int k = 0; k < rng_n; k++) if (!got00[rng_lo + k]) pre_err++;
            end
            8'hC0: begin
              if (cyc - t_data != TP + 1) time_err++;
              t_vcmd = cyc;
            end
            8'hA0: begin
              if (last_was_econf && (cyc - t_econf != TE + 1)) time_err++;
              t_vcmd = cyc;
            end
            8'h00: ;
            default: seq_err++;
          endcase
          last_was_econf = 0;
        end
      end
    end
  end

  // ---------------- stream source ----------------
  logic [7:0] src [16];
  int acc_cnt = 0, acc_base = 0, prev_acc = 0, feed_n = 0;
  bit feed_on = 1'b0;

  always @(posedge clk) if (wr_valid && wr_ready) acc_cnt <= acc_cnt + 1;

  always @(negedge clk) begin
    if (feed_on && (acc_cnt - acc_base) < feed_n) begin
      if (!(wr_valid && acc_cnt == prev_acc)) begin
        wr_valid = ($urandom % 3) != 0;
        wr_data  = src[acc_cnt - acc_base];
      end
    end else begin
      wr_valid = 1'b0;
    end
    prev_acc = acc_cnt;
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  task automatic model_reset(input bit er, input int lo, input int n);
    for (int k = 0; k < 16; k++) begin
      mem[k] = er ? 8'(($urandom % 2) ? 0 : $urandom) : 8'hFF;
      pcount[k] = 0; got00[k] = 1'b0; eneed[k] = 100000;
      pneed[k] = 1 + ($urandom % 3);
    end
    eglob = 0; epulses = 0; ptotal = 0; cmd_st = 0; last_was_econf = 0;
    seq_err = 0; time_err = 0; vpp_err = 0; pre_err = 0; last_w = -1;
    rng_lo = lo; rng_n = n;
  endtask

  function automatic int exp_prog(input int lo, input int n, output int pulses);
    int need;
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      need = (src[i] == 8'hFF) ? 1 : pneed[lo + i];
      if (need > PM) begin pulses += PM; return i; end
      pulses += need;
    end
    return -1;
  endfunction

  function automatic int exp_pre(input int lo, input int n);
    int s = 0;
    for (int i = 0; i < n; i++) s += (mem[lo + i] == 8'h00) ? 1 : pneed[lo + i];
    return s;
  endfunction

  function automatic int exp_erase(input int lo, input int n, output int pulses);
    int g = 0, p;
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      if (i == 0) p = (eneed[lo] > 1) ? eneed[lo] : 1;
      else        p = (eneed[lo + i] > g) ? eneed[lo + i] - g : 0;
      if (p > EM) begin pulses += EM; return i; end
      pulses += p; g += p;
    end
    return -1;
  endfunction

  task automatic run_op(input bit er, input bit both, input int poke, input int lo,
                        input int n, output bit ps, output int fa);
    int w = 0;
    @(negedge clk);
    op_addr = AW'(lo); op_count_m1 = AW'(n - 1);
    acc_base = acc_cnt; feed_n = er ? 0 : n; feed_on = !er;
    prog_start = !er; erase_start = er || both;
    @(negedge clk);
    prog_start = 1'b0; erase_start = 1'b0;
    while (!done && w < 30000) begin
      @(negedge clk); w++;
      prog_start = (w == poke); erase_start = (w == poke);
    end
    prog_start = 1'b0; erase_start = 1'b0;
    chk(done, "R10 done seen", done, 1);
    ps = pass; fa = int'(fail_addr);
    chk(last_w == 0, "R10 final read-array write", last_w, 0);
    @(negedge clk);
    chk(!done && !vpp_en && !busy, "R10 done one cycle, vpp dropped",
        {done, vpp_en, busy}, 0);
    feed_on = 1'b0;
    chk(seq_err == 0, "R2 command sequence", seq_err, 0);
    chk(time_err == 0, "R9 wait spacing", time_err, 0);
    chk(vpp_err == 0, "R10 vpp during writes", vpp_err, 0);
  endtask

  task automatic do_prog(input int lo, input int n, input int poke, input bit both);
    bit ps; int fa, efail, epls;
    efail = exp_prog(lo, n, epls);
    run_op(1'b0, both, poke, lo, n, ps, fa);
    chk(ps == (efail < 0), "R5 pass flag", ps, efail < 0);
    if (efail >= 0) chk(fa == lo + efail, "R5 fail address", fa, lo + efail);
    chk(ptotal == epls, "R4 program pulse total", ptotal, epls);
    chk(acc_cnt - acc_base == ((efail < 0) ? n : efail + 1), "R3 stream bytes taken",
        acc_cnt - acc_base, (efail < 0) ? n : efail + 1);
    chk(epulses == 0, "R11 no erase activity", epulses, 0);
    for (int i = 0; i < ((efail < 0) ? n : efail); i++)
      chk(mem[lo + i] == src[i], "R3 byte programmed", mem[lo + i], src[i]);
  endtask

  task automatic do_erase(input int lo, input int n);
    bit ps; int fa, efail, epls, ppls;
    ppls  = exp_pre(lo, n);
    efail = exp_erase(lo, n, epls);
    run_op(1'b1, 1'b0, 0, lo, n, ps, fa);
    chk(ps == (efail < 0), "R8 erase pass flag", ps, efail < 0);
    if (efail >= 0) chk(fa == lo + efail, "R8 erase fail address", fa, lo + efail);
    chk(epulses == epls, "R7 erase pulse total", epulses, epls);
    chk(ptotal == ppls, "R6 pre-program pulses", ptotal, ppls);
    chk(pre_err == 0, "R6 all bytes zeroed before erase", pre_err, 0);
    chk(acc_cnt == acc_base, "R6 no stream bytes", acc_cnt - acc_base, 0);
    if (efail < 0)
      for (int i = 0; i < n; i++) chk(mem[lo + i] == 8'hFF, "R7 byte erased", mem[lo + i], 255);
  endtask

  initial begin
    int lo, n;
    void'($urandom(32'd4242));
    model_reset(1'b0, 0, 0);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !vpp_en && !fl_we && !fl_re && !wr_ready, "R1 reset state",
        {busy, done, vpp_en, fl_we, fl_re, wr_ready}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !vpp_en && !fl_we, "R1 idle after reset", {busy, vpp_en, fl_we}, 0);

    // single byte, one pulse
    model_reset(1'b0, 3, 1); pneed[3] = 1; src[0] = 8'h5A;
    do_prog(3, 1, 0, 1'b0);

    // multi-pulse bytes (R4)
    model_reset(1'b0, 0, 4);
    pneed[0] = 3; pneed[1] = 1; pneed[2] = 5; pneed[3] = 2;
    src[0] = 8'h12; src[1] = 8'h34; src[2] = 8'h00; src[3] = 8'hA5;
    do_prog(0, 4, 0, 1'b0);

    // budget overrun at second byte (R5)
    model_reset(1'b0, 8, 3);
    pneed[8] = 2; pneed[9] = 6; pneed[10] = 1;
    src[0] = 8'h01; src[1] = 8'h02; src[2] = 8'h03;
    do_prog(8, 3, 0, 1'b0);

    // FF data verifies after one pulse even with a large need (R4)
    model_reset(1'b0, 5, 1); pneed[5] = 9; src[0] = 8'hFF;
    do_prog(5, 1, 0, 1'b0);

    // both starts together: program wins (R11)
    model_reset(1'b0, 2, 2); src[0] = 8'h77; src[1] = 8'h88;
    do_prog(2, 2, 0, 1'b1);

    // starts while busy are ignored (R11)
    model_reset(1'b0, 4, 3); src[0] = 8'h11; src[1] = 8'h22; src[2] = 8'h33;
    do_prog(4, 3, 10, 1'b0);
    repeat (3) @(negedge clk);
    chk(!busy, "R11 no queued start", busy, 0);

    // erase pass: total over budget, each address within (R7, R8)
    model_reset(1'b1, 2, 6);
    eneed[2] = 4; eneed[3] = 2; eneed[4] = 7; eneed[5] = 7; eneed[6] = 1; eneed[7] = 9;
    do_erase(2, 6);

    // erase budget overrun at second address (R8)
    model_reset(1'b1, 10, 2);
    eneed[10] = 3; eneed[11] = 10;
    do_erase(10, 2);

    // random program operations
    for (int r = 0; r < 8; r++) begin
      lo = $urandom % 12; n = 1 + ($urandom % (16 - lo < 6 ? 16 - lo : 6));
      model_reset(1'b0, lo, n);
      for (int i = 0; i < 16; i++) begin
        src[i] = 8'($urandom);
        pneed[i] = 1 + ($urandom % (PM + 1));
      end
      do_prog(lo, n, 0, 1'b0);
    end

    // random erase operations
    for (int r = 0; r < 3; r++) begin
      lo = $urandom % 10; n = 1 + ($urandom % 6);
      model_reset(1'b1, lo, n);
      for (int i = 0; i < n; i++) eneed[lo + i] = 1 + ($urandom % 8);
      do_erase(lo, n);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule